// File: doc/BRIEF.md
# Chained Hash Tag Table

This block keeps a small tag store arranged as a hash table. Each slot can hold one entry, and collisions are resolved by linking entries into doubly linked chains. A key selects its home slot through a fixed group of middle key bits. A chain starts at a slot marked as head, and that slot must be the home of every key in the chain. The other chain members live in spare slots that the caller supplies. Each entry carries its key, a heap pointer owned by the surrounding replacement logic, next and prev links, and valid, head and tail flags.

The caller issues one operation at a time: lookup, insert or remove. It waits for the one-cycle `done` pulse before it may rely on the results. `busy` is high while an operation runs, and a request is taken only in a cycle where `busy` is low. Each operation is carried out as a short sequence of single-slot writes, one per clock.

When a new key's home slot is held by a member of some other chain, that entry is moved to the supplied free slot and its neighbours are relinked. The new key then takes the home slot as a head. When a chain head with a successor is removed, the successor's contents are copied into the head slot. In both cases the block reports which slot the moved entry now occupies and its heap pointer, so the heap can fix its back reference.

Top module: `cht_table`

## Requirements
- R1: After a synchronous reset every slot is empty, `busy` and `done` are low, and any lookup misses.
- R2: The home slot of a key is key bits [5:2] with the default geometry (16 slots, 12-bit keys).
- R3: An insert whose home slot is empty writes the entry into the home slot as a single-entry chain with head and tail set, reports no move, and a later lookup hits at the home slot and returns the stored heap pointer.
- R4: An insert whose home slot holds a chain head places the entry in the supplied free slot, linked directly after the head; lookups of every chain member then hit at their own slots.
- R5: A lookup whose key is absent from its home chain walks the chain to the tail and reports a miss; a walk also stops after as many steps as there are slots.
- R6: An insert whose home slot holds a member of another chain moves that member to the free slot, relinks its neighbours, reports the move with the new slot index and the member's heap pointer, and stores the new key at its home slot as head.
- R7: A lookup whose home slot is valid but not a chain head reports a miss.
- R8: Removing a non-head entry unlinks it; if it was the tail, its predecessor becomes the tail and the chain stays usable for later inserts.
- R9: Removing a head that is also the tail empties the slot, so that a later insert for that home uses the home slot as an empty slot.
- R10: Removing a head that has a successor copies the successor into the head slot, frees the successor's slot, and reports the move with the head slot index and the successor's heap pointer.
- R11: `done` is a one-cycle pulse raised only while `busy` is low. A lookup that matches at its home slot, or an insert into an empty home, raises `done` in the second cycle after the cycle in which the request is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Request strobe, taken when `busy` is low |
| op_code | input | 2 | 0 lookup, 1 insert, 2 remove |
| op_key | input | 12 | Key for lookup and insert |
| op_hp | input | 8 | Heap pointer stored by insert |
| op_free | input | 4 | Free slot offered to insert |
| op_slot | input | 4 | Slot to remove |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Operation finished (one-cycle pulse) |
| hit | output | 1 | Lookup result: key found |
| hit_slot | output | 4 | Lookup result: slot of the match |
| hit_hp | output | 8 | Lookup result: heap pointer of the match |
| moved | output | 1 | The last insert or remove moved an entry |
| moved_slot | output | 4 | New slot of the moved entry |
| moved_hp | output | 8 | Heap pointer of the moved entry |

## Verification
Within a single clock cycle, one operation completes and the next request is accepted: the `done` pulse and the acceptance of a new request both occur in the idle cycle. Every bench scenario presents its next request in the same cycle in which the previous `done` is seen. The bench judges each result against the table contents that the requirements predict. A lookup issued immediately after an insert or a relocation must see every write of that insert or relocation. A dedicated timing scenario counts the cycles to `done` and confirms that the pulse lasts exactly one cycle once no further request follows.

// File: rtl/cht_pkg.sv
package cht_pkg;

    localparam int SLOTS  = 16;
    localparam int KEY_W  = 12;
    localparam int HP_W   = 8;
    localparam int IDX_LO = 2;
    localparam int IDX_W  = $clog2(SLOTS);
    localparam int MAXW   = 4;                 // longest write sequence
    localparam int K_W    = $clog2(MAXW);
    localparam int CNT_W  = $clog2(MAXW + 1);

    typedef logic [IDX_W-1:0] idx_t;
    typedef logic [KEY_W-1:0] key_t;
    typedef logic [HP_W-1:0]  hp_t;
    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_INSERT = 2'd1,
        OP_REMOVE = 2'd2
    } op_e;

    typedef struct packed {
        logic valid;
        logic head;
        logic tail;
        key_t key;
        hp_t  hp;
        idx_t nxt;
        idx_t prv;
    } slot_t;

    typedef enum logic [2:0] {
        W_NONE = 3'd0,
        W_FULL = 3'd1,   // overwrite whole slot
        W_SETN = 3'd2,   // replace next link
        W_SETP = 3'd3,   // replace prev link
        W_ENDP = 3'd4    // make slot the chain end
    } wkind_e;

    typedef struct packed {
        wkind_e kind;
        idx_t   idx;
        slot_t  ent;
        idx_t   ptr;
    } wstep_t;

endpackage

// File: rtl/cht_store.sv
module cht_store
    import cht_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  wstep_t wr,
    input  idx_t   ra_idx,
    input  idx_t   rb_idx,
    output slot_t  ra,
    output slot_t  rb
);

    slot_t mem [SLOTS];

    assign ra = mem[ra_idx];
    assign rb = mem[rb_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < SLOTS; i++) mem[i] <= '0;
        end else begin
            case (wr.kind)
                W_FULL: mem[wr.idx] <= wr.ent;
                W_SETN: mem[wr.idx].nxt <= wr.ptr;
                W_SETP: mem[wr.idx].prv <= wr.ptr;
                W_ENDP: begin
                    mem[wr.idx].nxt  <= wr.idx;
                    mem[wr.idx].tail <= 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R6: a head entry may only be written into its own home slot
    a_r6_head_at_home: assert property (@(posedge clk) disable iff (rst)
        (wr.kind == W_FULL && wr.ent.valid && wr.ent.head)
            |-> (wr.ent.key[IDX_LO +: IDX_W] == wr.idx));

    // R4: a chain member that is not head never sits in its own home slot
    a_r4_member_away: assert property (@(posedge clk) disable iff (rst)
        (wr.kind == W_FULL && wr.ent.valid && !wr.ent.head)
            |-> (wr.ent.key[IDX_LO +: IDX_W] != wr.idx));

endmodule

// File: rtl/cht_planner.sv
module cht_planner
    import cht_pkg::*;
(
    input  logic [1:0] op_code,
    input  key_t       key,
    input  hp_t        hp,
    input  idx_t       free_idx,
    input  idx_t       slot_idx,
    input  slot_t      a,        // slot at tgt
    input  logic       b_tail,   // fields of the slot after a
    input  key_t       b_key,
    input  hp_t        b_hp,
    input  idx_t       b_nxt,
    output idx_t       tgt,
    output wstep_t     steps [MAXW],
    output cnt_t       n,
    output logic       mv,
    output idx_t       mv_slot,
    output hp_t        mv_hp
);

    idx_t  h;
    slot_t fresh, link, moved_e, head_e;

    assign h   = key[IDX_LO +: IDX_W];
    assign tgt = (op_code == OP_REMOVE) ? slot_idx : h;

    always_comb begin
        for (int i = 0; i < MAXW; i++) steps[i] = '0;
        n       = '0;
        mv      = 1'b0;
        mv_slot = '0;
        mv_hp   = '0;

        fresh       = '0;
        fresh.valid = 1'b1;
        fresh.head  = 1'b1;
        fresh.tail  = 1'b1;
        fresh.key   = key;
        fresh.hp    = hp;
        fresh.nxt   = h;
        fresh.prv   = h;

        link        = '0;
        link.valid  = 1'b1;
        link.tail   = a.tail;
        link.key    = key;
        link.hp     = hp;
        link.nxt    = a.tail ? free_idx : a.nxt;
        link.prv    = h;

        moved_e     = a;
        if (a.tail) moved_e.nxt = free_idx;

        head_e       = '0;
        head_e.valid = 1'b1;
        head_e.head  = 1'b1;
        head_e.tail  = b_tail;
        head_e.key   = b_key;
        head_e.hp    = b_hp;
        head_e.nxt   = b_tail ? slot_idx : b_nxt;
        head_e.prv   = slot_idx;

        if (op_code == OP_INSERT) begin
            if (!a.valid) begin
                steps[0].kind = W_FULL; steps[0].idx = h; steps[0].ent = fresh;
                n = 3'd1;
            end else if (a.head) begin
                steps[0].kind = W_FULL; steps[0].idx = free_idx; steps[0].ent = link;
                steps[1].kind = W_FULL; steps[1].idx = h;        steps[1].ent = a;
                steps[1].ent.nxt  = free_idx;
                steps[1].ent.tail = 1'b0;
                n = 3'd2;
                if (!a.tail) begin
                    steps[2].kind = W_SETP; steps[2].idx = a.nxt; steps[2].ptr = free_idx;
                    n = 3'd3;
                end
            end else begin
                mv      = 1'b1;
                mv_slot = free_idx;
                mv_hp   = a.hp;
                steps[0].kind = W_FULL; steps[0].idx = free_idx; steps[0].ent = moved_e;
                steps[1].kind = W_SETN; steps[1].idx = a.prv;    steps[1].ptr = free_idx;
                if (a.tail) begin
                    steps[2].kind = W_FULL; steps[2].idx = h; steps[2].ent = fresh;
                    n = 3'd3;
                end else begin
                    steps[2].kind = W_SETP; steps[2].idx = a.nxt; steps[2].ptr = free_idx;
                    steps[3].kind = W_FULL; steps[3].idx = h;     steps[3].ent = fresh;
                    n = 3'd4;
                end
            end
        end else if (op_code == OP_REMOVE && a.valid) begin
            if (!a.head) begin
                if (a.tail) begin
                    steps[0].kind = W_ENDP; steps[0].idx = a.prv;
                    steps[1].kind = W_FULL; steps[1].idx = slot_idx;
                    n = 3'd2;
                end else begin
                    steps[0].kind = W_SETN; steps[0].idx = a.prv; steps[0].ptr = a.nxt;
                    steps[1].kind = W_SETP; steps[1].idx = a.nxt; steps[1].ptr = a.prv;
                    steps[2].kind = W_FULL; steps[2].idx = slot_idx;
                    n = 3'd3;
                end
            end else if (a.tail) begin
                steps[0].kind = W_FULL; steps[0].idx = slot_idx;
                n = 3'd1;
            end else begin
                mv      = 1'b1;
                mv_slot = slot_idx;
                mv_hp   = b_hp;
                steps[0].kind = W_FULL; steps[0].idx = slot_idx; steps[0].ent = head_e;
                if (b_tail) begin
                    steps[1].kind = W_FULL; steps[1].idx = a.nxt;
                    n = 3'd2;
                end else begin
                    steps[1].kind = W_SETP; steps[1].idx = b_nxt; steps[1].ptr = slot_idx;
                    steps[2].kind = W_FULL; steps[2].idx = a.nxt;
                    n = 3'd3;
                end
            end
        end
    end

endmodule

// File: rtl/cht_walker.sv
module cht_walker
    import cht_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  key_t key,
    input  idx_t home,
    input  logic e_valid,
    input  logic e_head,
    input  logic e_tail,
    input  key_t e_key,
    input  hp_t  e_hp,
    input  idx_t e_nxt,
    output idx_t rd_idx,
    output logic active,
    output logic fin,
    output logic hit,
    output idx_t hit_slot,
    output hp_t  hit_hp
);

    idx_t cur;
    idx_t cnt;
    key_t key_q;
    logic bad_start, found, stop;

    assign rd_idx    = cur;
    assign bad_start = (cnt == '0) && !(e_valid && e_head);
    assign found     = !bad_start && e_valid && (e_key == key_q);
    assign stop      = bad_start || found || e_tail || (cnt == idx_t'(SLOTS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            fin      <= 1'b0;
            hit      <= 1'b0;
            hit_slot <= '0;
            hit_hp   <= '0;
            cur      <= '0;
            cnt      <= '0;
            key_q    <= '0;
        end else begin
            fin <= 1'b0;
            if (start) begin
                active <= 1'b1;
                cur    <= home;
                cnt    <= '0;
                key_q  <= key;
            end else if (active) begin
                if (stop) begin
                    active   <= 1'b0;
                    fin      <= 1'b1;
                    hit      <= found;
                    hit_slot <= cur;
                    hit_hp   <= e_hp;
                end else begin
                    cur <= e_nxt;
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    // R11: completion of a walk lasts a single cycle
    a_r11_walk_pulse: assert property (@(posedge clk) disable iff (rst)
        fin |=> !fin);

endmodule

// File: rtl/cht_table.sv
module cht_table
    import cht_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             op_valid,
    input  logic [1:0]       op_code,
    input  logic [KEY_W-1:0] op_key,
    input  logic [HP_W-1:0]  op_hp,
    input  logic [IDX_W-1:0] op_free,
    input  logic [IDX_W-1:0] op_slot,
    output logic             busy,
    output logic             done,
    output logic             hit,
    output logic [IDX_W-1:0] hit_slot,
    output logic [HP_W-1:0]  hit_hp,
    output logic             moved,
    output logic [IDX_W-1:0] moved_slot,
    output logic [HP_W-1:0]  moved_hp
);

    slot_t  ra, rb;
    idx_t   ra_idx, tgt, wk_idx;
    wstep_t plan [MAXW];
    wstep_t steps_q [MAXW];
    wstep_t wr;
    cnt_t   plan_n, n_q;
    logic [K_W-1:0] k_q;
    logic   plan_mv, exec_on, done_x, wk_active, wk_fin, accept;
    idx_t   plan_mv_slot;
    hp_t    plan_mv_hp;

    assign busy   = exec_on || wk_active;
    assign accept = op_valid && !busy;
    assign done   = done_x || wk_fin;
    assign ra_idx = wk_active ? wk_idx : tgt;
    assign wr     = exec_on ? steps_q[k_q] : '0;

    cht_store u_store (
        .clk(clk), .rst(rst), .wr(wr),
        .ra_idx(ra_idx), .rb_idx(ra.nxt), .ra(ra), .rb(rb)
    );

    cht_planner u_plan (
        .op_code(op_code), .key(op_key), .hp(op_hp),
        .free_idx(op_free), .slot_idx(op_slot), .a(ra),
        .b_tail(rb.tail), .b_key(rb.key), .b_hp(rb.hp), .b_nxt(rb.nxt),
        .tgt(tgt), .steps(plan), .n(plan_n),
        .mv(plan_mv), .mv_slot(plan_mv_slot), .mv_hp(plan_mv_hp)
    );

    cht_walker u_walk (
        .clk(clk), .rst(rst),
        .start(accept && op_code == OP_LOOKUP),
        .key(op_key), .home(tgt),
        .e_valid(ra.valid), .e_head(ra.head), .e_tail(ra.tail),
        .e_key(ra.key), .e_hp(ra.hp), .e_nxt(ra.nxt),
        .rd_idx(wk_idx), .active(wk_active), .fin(wk_fin),
        .hit(hit), .hit_slot(hit_slot), .hit_hp(hit_hp)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            exec_on    <= 1'b0;
            done_x     <= 1'b0;
            n_q        <= '0;
            k_q        <= '0;
            moved      <= 1'b0;
            moved_slot <= '0;
            moved_hp   <= '0;
            for (int i = 0; i < MAXW; i++) steps_q[i] <= '0;
        end else begin
            done_x <= 1'b0;
            if (accept) begin
                moved      <= (op_code == OP_LOOKUP) ? 1'b0 : plan_mv;
                moved_slot <= plan_mv_slot;
                moved_hp   <= plan_mv_hp;
                if (op_code != OP_LOOKUP) begin
                    steps_q <= plan;
                    n_q     <= plan_n;
                    k_q     <= '0;
                    if (plan_n == '0) done_x  <= 1'b1;
                    else              exec_on <= 1'b1;
                end
            end else if (exec_on) begin
                k_q <= k_q + 1'b1;
                if (cnt_t'(k_q) == n_q - cnt_t'(1)) begin
                    exec_on <= 1'b0;
                    done_x  <= 1'b1;
                end
            end
        end
    end

    // R11: completion is only signalled while idle
    a_r11_done_idle: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R10: a head with a successor points at a valid non-head entry that links back
    a_r10_succ_links_back: assert property (@(posedge clk) disable iff (rst)
        (accept && op_code == OP_REMOVE && ra.valid && ra.head && !ra.tail)
            |-> (rb.valid && !rb.head && rb.prv == op_slot));

    // R6: every move takes at least two slot writes
    a_r6_move_writes: assert property (@(posedge clk) disable iff (rst)
        (accept && plan_mv && op_code != OP_LOOKUP) |-> (plan_n >= cnt_t'(2)));

endmodule

// File: tb/cht_table_bench.sv
module cht_table_bench;
    import cht_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic op_valid = 1'b0;
    logic [1:0] op_code = '0;
    key_t op_key = '0;
    hp_t  op_hp = '0;
    idx_t op_free = '0;
    idx_t op_slot = '0;
    logic busy, done, hit, moved;
    idx_t hit_slot, moved_slot;
    hp_t  hit_hp, moved_hp;

    int total = 0;
    int bad = 0;
    int last_cyc = 0;
    logic finished = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cht_table u_cht_table (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_key(op_key), .op_hp(op_hp), .op_free(op_free), .op_slot(op_slot),
        .busy(busy), .done(done), .hit(hit), .hit_slot(hit_slot), .hit_hp(hit_hp),
        .moved(moved), .moved_slot(moved_slot), .moved_hp(moved_hp)
    );

    task automatic check(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // drives at a falling edge, returns at the falling edge where done is seen
    task automatic run_op(logic [1:0] code, key_t k, hp_t p, idx_t f, idx_t s);
        int cyc;
        op_valid = 1'b1; op_code = code; op_key = k; op_hp = p; op_free = f; op_slot = s;
        @(negedge clk);
        op_valid = 1'b0;
        cyc = 1;
        while (!done && cyc < 50) begin
            @(negedge clk);
            cyc++;
        end
        last_cyc = cyc;
        if (!done) begin
            total++; bad++;
            $display("FAIL R11: actual=no done expected=done");
        end
    endtask

    task automatic look(string req, key_t k, logic exp_hit, idx_t exp_slot, hp_t exp_hp);
        run_op(OP_LOOKUP, k, '0, '0, '0);
        check({req, " hit"}, hit, exp_hit);
        if (exp_hit) begin
            check({req, " slot"}, hit_slot, exp_slot);
            check({req, " hp"}, hit_hp, exp_hp);
        end
    endtask

    task automatic ins(string req, key_t k, hp_t p, idx_t f, logic exp_mv, idx_t mv_s, hp_t mv_p);
        run_op(OP_INSERT, k, p, f, '0);
        check({req, " moved"}, moved, exp_mv);
        if (exp_mv) begin
            check({req, " moved_slot"}, moved_slot, mv_s);
            check({req, " moved_hp"}, moved_hp, mv_p);
        end
    endtask

    task automatic rem(string req, idx_t s, logic exp_mv, idx_t mv_s, hp_t mv_p);
        run_op(OP_REMOVE, '0, '0, '0, s);
        check({req, " moved"}, moved, exp_mv);
        if (exp_mv) begin
            check({req, " moved_slot"}, moved_slot, mv_s);
            check({req, " moved_hp"}, moved_hp, mv_p);
        end
    endtask

    task automatic t_reset();
        check("R1 busy", busy, 0);
        check("R1 done", done, 0);
        look("R1", 12'h00C, 1'b0, '0, '0);
    endtask

    task automatic t_empty_home();
        ins("R3", 12'h00C, 8'h11, 4'd9, 1'b0, '0, '0);
        check("R11 insert latency", last_cyc, 2);
        look("R3 R2", 12'h00C, 1'b1, 4'd3, 8'h11);
        check("R11 lookup latency", last_cyc, 2);
    endtask

    task automatic t_head_chain();
        ins("R4", 12'h10C, 8'h22, 4'd7, 1'b0, '0, '0);
        look("R4 new", 12'h10C, 1'b1, 4'd7, 8'h22);
        look("R4 head", 12'h00C, 1'b1, 4'd3, 8'h11);
        ins("R4 third", 12'h20C, 8'h33, 4'd8, 1'b0, '0, '0);
        look("R4 third", 12'h20C, 1'b1, 4'd8, 8'h33);
        look("R5 absent", 12'h30C, 1'b0, '0, '0);
    endtask

    task automatic t_foreign();
        look("R7", 12'h01C, 1'b0, '0, '0);
        ins("R6", 12'h01C, 8'h44, 4'd10, 1'b1, 4'd10, 8'h22);
        look("R6 new", 12'h01C, 1'b1, 4'd7, 8'h44);
        look("R6 relocated", 12'h10C, 1'b1, 4'd10, 8'h22);
    endtask

    task automatic t_remove_member();
        rem("R8 mid", 4'd8, 1'b0, '0, '0);
        look("R8 gone", 12'h20C, 1'b0, '0, '0);
        look("R8 tail kept", 12'h10C, 1'b1, 4'd10, 8'h22);
        rem("R8 tail", 4'd10, 1'b0, '0, '0);
        look("R8 tail gone", 12'h10C, 1'b0, '0, '0);
        look("R8 head kept", 12'h00C, 1'b1, 4'd3, 8'h11);
        ins("R8 relink", 12'h30C, 8'h55, 4'd12, 1'b0, '0, '0);
        look("R8 relink", 12'h30C, 1'b1, 4'd12, 8'h55);
    endtask

    task automatic t_remove_head();
        rem("R10", 4'd3, 1'b1, 4'd3, 8'h55);
        look("R10 copied", 12'h30C, 1'b1, 4'd3, 8'h55);
        look("R10 old head", 12'h00C, 1'b0, '0, '0);
        rem("R9", 4'd7, 1'b0, '0, '0);
        look("R9 gone", 12'h01C, 1'b0, '0, '0);
        ins("R9 reuse", 12'h11C, 8'h66, 4'd13, 1'b0, '0, '0);
        look("R9 reuse", 12'h11C, 1'b1, 4'd7, 8'h66);
    endtask

    task automatic t_pulse();
        look("R11", 12'h11C, 1'b1, 4'd7, 8'h66);
        check("R11 latency", last_cyc, 2);
        @(negedge clk);
        check("R11 pulse width", done, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_empty_home();
        t_head_chain();
        t_foreign();
        t_remove_member();
        t_remove_head();
        t_pulse();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule